// File: doc/BRIEF.md
# Flyback Controller Operating-State Supervisor

This block is the top-level mode controller of a primary-side-regulated flyback converter. It sees the analog world only through digital comparator flags: the supply crossing its turn-on and turn-off levels, the per-cycle peak of the auxiliary-winding sense crossing three references (arm, trigger, over-voltage), and a pair of over-temperature flags. It decides whether the switching timer may run. When the timer may run, the block also tells it whether to use the fixed low-frequency on/off times or the regulated steady-state timing. It tells the timer to halt when a fault latch is active.

After power-up the block waits in a startup state. When the supply is high enough it probes the output with fixed low-frequency pulses. Once the auxiliary peak shows a real load voltage, it moves to steady regulation. A shorted output makes it fall back to probing. A persistent over-voltage, which indicates an open load, latches switching off until the supply collapses, and that collapse gives an automatic restart. Over-temperature stops switching at once and holds it off until the cool flag is seen. All peak comparisons are taken only on the timer's end-of-cycle strobe.

Top module: `fss_top`

## Requirements
- R1: After synchronous reset, `state_o` is 5'b00001 (startup), and `sw_en_o`, `lowfreq_o` and `halt_o` are all 0.
- R2: In startup, `vcc_on_i` high with no thermal fault moves the block to low-frequency on the next clock edge. Strobes and peak flags have no effect in startup.
- R3: In low-frequency (`state_o` = 5'b00010), `sw_en_o`=1 and `lowfreq_o`=1. In steady (5'b00100), `sw_en_o`=1 and `lowfreq_o`=0. In both states `halt_o`=0.
- R4: In low-frequency, a strobe with `pk_arm_i` high moves the block to steady. `pk_arm_i` without a strobe is ignored.
- R5: In steady, a strobe with `pk_trig_i` low (shorted output) returns the block to low-frequency.
- R6: In steady, `OVP_CYCLES` (default 3) consecutive strobes with `pk_ovp_i` high move the block to the over-voltage latch (5'b01000), with `halt_o`=1 and `sw_en_o`=0.
- R7: The over-voltage streak restarts on any strobe with `pk_ovp_i` low and on every state change.
- R8: `vcc_off_i` sends every state to startup on the next edge. It has the highest priority after reset.
- R9: `ot_hot_i` in low-frequency or steady moves the block to thermal shutdown (5'b10000) on the next edge, with `sw_en_o`=0 and `halt_o`=1. `ot_hot_i` also blocks the startup exit.
- R10: The block leaves thermal shutdown for low-frequency only in the cycle after `ot_clear_i` is seen high while `ot_hot_i` is low.
- R11: The over-voltage latch ignores strobes, peak flags and `vcc_on_i`. Only `vcc_off_i` releases it.
- R12: `state_o` is always one-hot, with bit 0 for startup, bit 1 for low-frequency, bit 2 for steady, bit 3 for the over-voltage latch and bit 4 for thermal shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_off_i | input | 1 | Supply below turn-off level |
| cyc_end_i | input | 1 | One-cycle end-of-switching-cycle strobe |
| pk_arm_i | input | 1 | Cycle peak above arm reference |
| pk_trig_i | input | 1 | Cycle peak above trigger reference |
| pk_ovp_i | input | 1 | Cycle peak above over-voltage reference |
| ot_hot_i | input | 1 | Over-temperature asserted |
| ot_clear_i | input | 1 | Temperature back below release level |
| state_o | output | 5 | One-hot operating state |
| sw_en_o | output | 1 | Switching timer may run |
| lowfreq_o | output | 1 | Timer must use fixed low-frequency timing |
| halt_o | output | 1 | Fault latch active, timer stopped |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it. `state_o` and the three controls are registered together from the same next-state decision. No result takes two edges, so the delay always counts one register. The bench changes inputs just after a falling edge and reads the outputs at the next falling edge, which means exactly one rising edge has passed. The over-voltage streak is checked strobe by strobe, so the transition must land on the third strobe and on no earlier one.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int ST_W = 5;

  typedef enum logic [ST_W-1:0] {
    ST_START = 5'b00001,
    ST_LOWF  = 5'b00010,
    ST_RUN   = 5'b00100,
    ST_OVL   = 5'b01000,
    ST_THERM = 5'b10000
  } op_state_t;
endpackage

// File: rtl/fss_thermal_gate.sv
module fss_thermal_gate (
  input  logic clk,
  input  logic rst,
  input  logic ot_hot_i,
  input  logic ot_clear_i,
  output logic hot_eff_o
);
  logic hot_q;

  // Set wins over clear; the effective flag reacts in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)              hot_q <= 1'b0;
    else if (ot_hot_i)    hot_q <= 1'b1;
    else if (ot_clear_i)  hot_q <= 1'b0;
  end

  assign hot_eff_o = ot_hot_i | (hot_q & ~ot_clear_i);

  // R9: a hot flag leaves the latch set on the next cycle
  a_r9_hot_latches: assert property (@(posedge clk) disable iff (rst)
    ot_hot_i |=> hot_q);
endmodule

// File: rtl/fss_ov_streak.sv
module fss_ov_streak #(
  parameter int OVP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic clear_i,
  input  logic strobe_i,
  input  logic ovp_i,
  output logic hit_o
);
  localparam int CW = (OVP_CYCLES > 1) ? $clog2(OVP_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = enable_i & strobe_i & ovp_i & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear_i || !enable_i) cnt_q <= '0;
    else if (strobe_i) begin
      if (!ovp_i)          cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: a strobe without over-voltage restarts the streak
  a_r7_streak_clear: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && !ovp_i) |=> (cnt_q == '0));
  // R6: the streak never runs past its limit
  a_r6_streak_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/fss_fsm.sv
module fss_fsm
  import fss_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      vcc_on_i,
  input  logic      vcc_off_i,
  input  logic      strobe_i,
  input  logic      pk_arm_i,
  input  logic      pk_trig_i,
  input  logic      hot_i,
  input  logic      ov_hit_i,
  output op_state_t state_q,
  output op_state_t state_d,
  output logic      changing_o
);
  always_comb begin
    state_d = state_q;
    if (vcc_off_i) state_d = ST_START;
    else begin
      unique case (state_q)
        ST_START: if (vcc_on_i && !hot_i) state_d = ST_LOWF;
        ST_LOWF: begin
          if (hot_i)                      state_d = ST_THERM;
          else if (strobe_i && pk_arm_i)  state_d = ST_RUN;
        end
        ST_RUN: begin
          if (hot_i)                      state_d = ST_THERM;
          else if (ov_hit_i)              state_d = ST_OVL;
          else if (strobe_i && !pk_trig_i) state_d = ST_LOWF;
        end
        ST_OVL:   state_d = ST_OVL;
        ST_THERM: if (!hot_i) state_d = ST_LOWF;
        default:  state_d = ST_START;
      endcase
    end
  end

  assign changing_o = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_START;
    else     state_q <= state_d;
  end

  // R12: state stays one-hot
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(state_q));
  // R8: supply collapse always restarts
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    vcc_off_i |=> (state_q == ST_START));
  // R11: latch holds without supply collapse
  a_r11_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OVL && !vcc_off_i) |=> (state_q == ST_OVL));
  // R4: without a strobe, low-frequency does not advance to steady
  a_r4_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOWF && !strobe_i) |=> (state_q != ST_RUN));
endmodule

// File: rtl/fss_top.sv
module fss_top
  import fss_pkg::*;
#(
  parameter int OVP_CYCLES = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vcc_on_i,
  input  logic            vcc_off_i,
  input  logic            cyc_end_i,
  input  logic            pk_arm_i,
  input  logic            pk_trig_i,
  input  logic            pk_ovp_i,
  input  logic            ot_hot_i,
  input  logic            ot_clear_i,
  output logic [ST_W-1:0] state_o,
  output logic            sw_en_o,
  output logic            lowfreq_o,
  output logic            halt_o
);
  logic      hot_eff;
  logic      ov_hit;
  logic      changing;
  op_state_t st_q, st_d;
  logic      en_q, lf_q, halt_q;

  fss_thermal_gate u_therm (
    .clk(clk), .rst(rst), .ot_hot_i(ot_hot_i), .ot_clear_i(ot_clear_i),
    .hot_eff_o(hot_eff)
  );

  fss_ov_streak #(.OVP_CYCLES(OVP_CYCLES)) u_ovs (
    .clk(clk), .rst(rst), .enable_i(st_q == ST_RUN), .clear_i(changing),
    .strobe_i(cyc_end_i), .ovp_i(pk_ovp_i), .hit_o(ov_hit)
  );

  fss_fsm u_fsm (
    .clk(clk), .rst(rst), .vcc_on_i(vcc_on_i), .vcc_off_i(vcc_off_i),
    .strobe_i(cyc_end_i), .pk_arm_i(pk_arm_i), .pk_trig_i(pk_trig_i),
    .hot_i(hot_eff), .ov_hit_i(ov_hit), .state_q(st_q), .state_d(st_d),
    .changing_o(changing)
  );

  // Controls registered from the next state, aligned with state_o.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      lf_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      en_q   <= (st_d == ST_LOWF) || (st_d == ST_RUN);
      lf_q   <= (st_d == ST_LOWF);
      halt_q <= (st_d == ST_OVL) || (st_d == ST_THERM);
    end
  end

  assign state_o   = st_q;
  assign sw_en_o   = en_q;
  assign lowfreq_o = lf_q;
  assign halt_o    = halt_q;

  // R9: over-temperature while running stops switching next edge
  a_r9_hot_stops: assert property (@(posedge clk) disable iff (rst)
    (ot_hot_i && !vcc_off_i) |=> !sw_en_o);
  // R6: halt and enable never coexist
  a_r6_halt_excl: assert property (@(posedge clk) disable iff (rst)
    !(halt_o && sw_en_o));
  // R3: low-frequency command only while enabled
  a_r3_lf_enabled: assert property (@(posedge clk) disable iff (rst)
    lowfreq_o |-> sw_en_o);
endmodule

// File: tb/fss_top_tb.sv
module fss_top_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic vcc_on = 0, vcc_off = 0, strobe = 0, arm = 0, trig = 0, ovp = 0;
  logic hot = 0, cool = 0;
  logic [4:0] st;
  logic en, lf, halt;
  int errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;

  fss_top u_dut (
    .clk(clk), .rst(rst), .vcc_on_i(vcc_on), .vcc_off_i(vcc_off),
    .cyc_end_i(strobe), .pk_arm_i(arm), .pk_trig_i(trig), .pk_ovp_i(ovp),
    .ot_hot_i(hot), .ot_clear_i(cool), .state_o(st), .sw_en_o(en),
    .lowfreq_o(lf), .halt_o(halt)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Expected outputs from state index: 0 start,1 lowf,2 run,3 ovl,4 therm
  task automatic expect_state(input int idx, input string req);
    logic [4:0] e_st;
    logic e_en, e_lf, e_halt;
    e_st = 5'b1 << idx;
    e_en = (idx == 1) || (idx == 2);
    e_lf = (idx == 1);
    e_halt = (idx == 3) || (idx == 4);
    checks++;
    if (st !== e_st || en !== e_en || lf !== e_lf || halt !== e_halt) begin
      errors++;
      $display("FAIL %s: state=%b en=%b lf=%b halt=%b expected state=%b en=%b lf=%b halt=%b",
               req, st, en, lf, halt, e_st, e_en, e_lf, e_halt);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_strobe(input logic a, input logic t, input logic o);
    arm = a; trig = t; ovp = o; strobe = 1;
    tick();
    strobe = 0; arm = 0; trig = 0; ovp = 0;
  endtask

  task automatic do_reset();
    rst = 1; vcc_on = 0; vcc_off = 0; strobe = 0; hot = 0; cool = 0;
    tick(); tick();
    rst = 0;
  endtask

  task automatic reach(input int idx);
    do_reset();
    if (idx >= 1) begin vcc_on = 1; tick(); vcc_on = 0; end
    if (idx == 2 || idx == 3) pulse_strobe(1, 1, 0);
    if (idx == 3) for (int k = 0; k < 3; k++) pulse_strobe(1, 1, 1);
    if (idx == 4) begin hot = 1; tick(); hot = 0; end
  endtask

  initial begin
    tick();
    do_reset();
    expect_state(0, "R1 reset state");

    // R2: strobe with peaks has no effect in startup
    pulse_strobe(1, 1, 1);
    expect_state(0, "R2 strobe ignored in startup");
    vcc_on = 1; tick(); vcc_on = 0;
    expect_state(1, "R2/R3 startup to low-frequency");

    // R4: arm without strobe ignored, then strobe advances
    arm = 1; tick(); tick(); arm = 0;
    expect_state(1, "R4 arm without strobe ignored");
    pulse_strobe(0, 1, 0);
    expect_state(1, "R4 strobe without arm stays");
    pulse_strobe(1, 1, 0);
    expect_state(2, "R4/R3 low-frequency to steady");

    // R5: shorted output
    pulse_strobe(1, 1, 0);
    expect_state(2, "R5 healthy peak stays steady");
    pulse_strobe(0, 0, 0);
    expect_state(1, "R5 low peak returns to low-frequency");

    // R6: exact streak length, sweep strobes 1..3
    reach(2);
    for (int k = 1; k <= 3; k++) begin
      pulse_strobe(1, 1, 1);
      expect_state(k < 3 ? 2 : 3, "R6 over-voltage streak");
    end

    // R7: break in streak restarts count
    reach(2);
    pulse_strobe(1, 1, 1); pulse_strobe(1, 1, 1);
    pulse_strobe(1, 1, 0);
    pulse_strobe(1, 1, 1); pulse_strobe(1, 1, 1);
    expect_state(2, "R7 streak restarted after clean cycle");
    pulse_strobe(1, 1, 1);
    expect_state(3, "R7 fresh streak completes");

    // R7: state change clears streak (2 ovp, drop to lowf, back)
    reach(2);
    pulse_strobe(1, 1, 1); pulse_strobe(1, 1, 1);
    pulse_strobe(0, 0, 0);
    pulse_strobe(1, 1, 0);
    pulse_strobe(1, 1, 1);
    expect_state(2, "R7 streak cleared by state change");

    // R11: latch ignores everything but supply collapse
    reach(3);
    vcc_on = 1; pulse_strobe(1, 1, 0); pulse_strobe(0, 0, 0); vcc_on = 0;
    expect_state(3, "R11 latch holds");

    // R8: sweep supply collapse from every state
    for (int s = 0; s < 5; s++) begin
      reach(s);
      expect_state(s, "R12 reached state encoding");
      vcc_off = 1; vcc_on = 1; hot = (s == 4); tick();
      vcc_off = 0; vcc_on = 0; hot = 0;
      expect_state(0, "R8 supply collapse to startup");
    end

    // R9/R10: thermal
    reach(2);
    hot = 1; tick(); hot = 0;
    expect_state(4, "R9 hot stops switching");
    tick(); tick();
    expect_state(4, "R10 stays off without clear");
    cool = 1; tick(); cool = 0;
    expect_state(1, "R10 clear resumes low-frequency");

    reach(1);
    hot = 1; tick();
    cool = 1; tick();
    expect_state(4, "R10 clear with hot high ignored");
    hot = 0; tick(); cool = 0;
    expect_state(1, "R10 clear after hot drops");

    do_reset();
    hot = 1; vcc_on = 1; tick(); hot = 0; tick(); vcc_on = 0;
    expect_state(0, "R9 hot blocks startup exit");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule